// File: doc/BRIEF.md
# Configurable UART Receive Framer

This block recovers characters from an asynchronous serial line. It runs in the system clock domain and advances its bit timing only on a one-cycle enable pulse that arrives sixteen times per bit period. It finds the falling edge of a start bit and confirms it halfway through the bit. It then samples each data bit in the middle of its bit period and checks the first stop bit. For every frame it produces one 10-bit result word: the character in the low bits, a per-character parity error (or the ninth data bit) in bit 8, and a framing error in bit 9.

The frame format comes from a 3-bit format code, a 2-bit stop-length code and an odd-parity select. The receiver copies these inputs when it accepts a start bit, so a frame is always decoded in the format it began with. A receive-enable input gates the detection of new frames. A loopback input makes the receiver listen to the local transmit line instead of the external pin. The result word is offered as a single-cycle pulse to whatever storage follows.

Top module: `uart_rx_framer`

## Requirements
- R1: Format code 1 receives 8 data bits, least significant bit first, into word[7:0], with word[8] = 0.
- R2: Format code 7 receives 8 data bits and then a parity bit. word[8] is set when the parity does not match. The parity is odd when `par_odd_i` = 1 and even otherwise.
- R3: Format code 3 receives 7 data bits and then a parity bit. word[6:0] holds the data, word[7] = 0, and word[8] flags a parity mismatch under the same odd/even rule as R2.
- R4: Format codes 4 (9-bit) and 5 (8-bit with wake-up bit) receive 9 bits. The ninth bit lands in word[8], no parity check is made, and `par_odd_i` has no effect.
- R5: word[9] is set when the line is low at the sample point of the first stop bit. A break (line held low) yields exactly one word, 0x200 in format 1, and no further word until the line has returned high.
- R6: A low pulse is taken as a start bit only if the line is still low at the 8th tick of 16. A shorter pulse produces no word.
- R7: Stop code 0 (half bit) samples the stop bit 12 ticks after the last data sample, so frames with half-bit stops can follow each other back to back. Codes 1, 2 and 3 (one, one and a half, two bits) sample the stop bit in the middle of the first full stop bit.
- R8: While `rx_en_i` = 0, no new frame is started and no word is produced.
- R9: With `loop_en_i` = 1 the receiver listens only to `tx_i` and ignores `rx_i`. With `loop_en_i` = 0 it listens only to `rx_i` and ignores `tx_i`.
- R10: Format codes 0, 2 and 6 are unsupported. No frame is started while one of them is selected.
- R11: Format, stop and parity inputs are captured at start-bit detection. A change during a frame does not affect that frame's word.
- R12: `word_valid_o` is low after reset and is a single-cycle pulse per received frame. A reset in the middle of a frame produces no word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick16_i | input | 1 | Oversampling enable, 16 pulses per bit period |
| fmt_i | input | 3 | Frame format code (1, 3, 4, 5, 7 valid) |
| stop_i | input | 2 | Stop length code: 0 half, 1 one, 2 one and a half, 3 two bits |
| par_odd_i | input | 1 | 1 selects odd parity, 0 even |
| loop_en_i | input | 1 | 1 routes the transmit line into the receiver |
| rx_en_i | input | 1 | Receive enable |
| rx_i | input | 1 | External serial input, idle high |
| tx_i | input | 1 | Local transmit line, used in loopback |
| word_valid_o | output | 1 | One-cycle pulse when a result word is ready |
| word_o | output | 10 | {frame error, parity error or ninth bit, data[7:0]} |

## Verification
On every cycle the assertions check that the result pulse lasts one cycle and follows a timing tick, and that no word appears in an unsupported format. They also check that bit 8 stays clear in plain 8-bit framing, that bit 7 stays clear in 7-bit framing, and that the receiver stays idle while reception is off. The bench scenarios are needed for the rest: the bit values themselves, the parity verdicts under odd and even selection, and break and framing-error detection at the stop sample. The scenarios also cover the half-bit stop spacing, glitch rejection, the loopback source selection, and the capture of the format at the start bit.

// File: rtl/uart_rxf_pkg.sv
package uart_rxf_pkg;

    // Frame format codes
    localparam logic [2:0] FMT_8N = 3'd1;   // 8 data, no parity
    localparam logic [2:0] FMT_7P = 3'd3;   // 7 data + parity
    localparam logic [2:0] FMT_9D = 3'd4;   // 9 data
    localparam logic [2:0] FMT_8W = 3'd5;   // 8 data + wake-up bit
    localparam logic [2:0] FMT_8P = 3'd7;   // 8 data + parity

    localparam int SHIFT_W = 9;
    localparam int WORD_W  = 10;

    typedef enum logic [1:0] {
        STOP_HALF    = 2'd0,
        STOP_ONE     = 2'd1,
        STOP_ONEHALF = 2'd2,
        STOP_TWO     = 2'd3
    } stop_len_e;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_START = 3'd1,
        ST_DATA  = 3'd2,
        ST_STOP  = 3'd3,
        ST_HOLD  = 3'd4
    } rx_state_e;

    typedef struct packed {
        logic [2:0] mode;
        stop_len_e  stop;
        logic       odd;
    } frame_cfg_t;

    typedef struct packed {
        logic       ferr;
        logic       hi;     // parity error or ninth data bit
        logic [7:0] data;
    } rx_word_t;

    function automatic logic fmt_ok(input logic [2:0] m);
        return (m == FMT_8N) || (m == FMT_7P) || (m == FMT_9D) ||
               (m == FMT_8W) || (m == FMT_8P);
    endfunction

    // Number of serial bits between start and stop, parity included
    function automatic logic [3:0] fmt_nbits(input logic [2:0] m);
        logic [3:0] n;
        case (m)
            FMT_8N, FMT_7P: n = 4'd8;
            default:        n = 4'd9;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/uart_rxf_linesel.sv
module uart_rxf_linesel #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic loop_en_i,
    input  logic rx_i,
    input  logic tx_i,
    output logic line_o
);
    logic                   raw_line;
    logic [SYNC_STAGES-1:0] sync_q;

    assign raw_line = loop_en_i ? tx_i : rx_i;

    generate
        for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) sync_q[0] <= 1'b1;
                    else     sync_q[0] <= raw_line;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) sync_q[g] <= 1'b1;
                    else     sync_q[g] <= sync_q[g-1];
                end
            end
        end
    endgenerate

    assign line_o = sync_q[SYNC_STAGES-1];
endmodule

// File: rtl/uart_rxf_sampler.sv
module uart_rxf_sampler
    import uart_rxf_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tick_i,
    input  logic                 line_i,
    input  logic                 en_i,
    input  frame_cfg_t           cfg_i,
    output logic                 done_o,
    output logic [SHIFT_W-1:0]   bits_o,
    output logic                 stop_ok_o,
    output logic [2:0]           mode_o,
    output logic                 odd_o,
    output rx_state_e            state_o
);
    localparam int CNT_W = $clog2(OVS);
    localparam logic [CNT_W-1:0] MID_CNT  = CNT_W'(OVS/2 - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(OVS - 1);
    localparam logic [CNT_W-1:0] HALF_CNT = CNT_W'(OVS/2 + OVS/4 - 1);

    rx_state_e          state_q;
    logic [CNT_W-1:0]   cnt_q;
    logic [3:0]         bitn_q;
    logic [SHIFT_W-1:0] sh_q;
    logic [SHIFT_W-1:0] frame_q;
    logic               stop_ok_q;
    logic               done_q;
    frame_cfg_t         cfg_q;
    logic [3:0]         last_bit;
    logic [CNT_W-1:0]   stop_pt;

    assign last_bit = fmt_nbits(cfg_q.mode) - 4'd1;
    assign stop_pt  = (cfg_q.stop == STOP_HALF) ? HALF_CNT : FULL_CNT;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            cnt_q     <= '0;
            bitn_q    <= '0;
            sh_q      <= '0;
            frame_q   <= '0;
            stop_ok_q <= 1'b1;
            done_q    <= 1'b0;
            cfg_q     <= '{mode: FMT_8N, stop: STOP_ONE, odd: 1'b0};
        end else begin
            done_q <= 1'b0;
            if (tick_i) begin
                case (state_q)
                    ST_IDLE: begin
                        if (en_i && fmt_ok(cfg_i.mode) && !line_i) begin
                            state_q <= ST_START;
                            cnt_q   <= '0;
                            cfg_q   <= cfg_i;
                        end
                    end
                    ST_START: begin
                        if (cnt_q == MID_CNT) begin
                            cnt_q  <= '0;
                            bitn_q <= '0;
                            state_q <= line_i ? ST_IDLE : ST_DATA;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    ST_DATA: begin
                        if (cnt_q == FULL_CNT) begin
                            cnt_q <= '0;
                            sh_q  <= {line_i, sh_q[SHIFT_W-1:1]};
                            if (bitn_q == last_bit) state_q <= ST_STOP;
                            else                    bitn_q  <= bitn_q + 4'd1;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    ST_STOP: begin
                        if (cnt_q == stop_pt) begin
                            cnt_q     <= '0;
                            done_q    <= 1'b1;
                            stop_ok_q <= line_i;
                            frame_q   <= (fmt_nbits(cfg_q.mode) == 4'd8) ?
                                         {1'b0, sh_q[SHIFT_W-1:1]} : sh_q;
                            state_q   <= line_i ? ST_IDLE : ST_HOLD;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    ST_HOLD: begin
                        if (line_i) state_q <= ST_IDLE;
                    end
                    default: state_q <= ST_IDLE;
                endcase
            end
        end
    end

    assign done_o    = done_q;
    assign bits_o    = frame_q;
    assign stop_ok_o = stop_ok_q;
    assign mode_o    = cfg_q.mode;
    assign odd_o     = cfg_q.odd;
    assign state_o   = state_q;
endmodule

// File: rtl/uart_rxf_pack.sv
module uart_rxf_pack
    import uart_rxf_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               done_i,
    input  logic [SHIFT_W-1:0] bits_i,
    input  logic               stop_ok_i,
    input  logic [2:0]         mode_i,
    input  logic               odd_i,
    output logic               valid_o,
    output logic [WORD_W-1:0]  word_o,
    output logic [2:0]         mode_o
);
    rx_word_t next_word;
    rx_word_t word_q;
    logic     valid_q;
    logic [2:0] mode_q;

    always_comb begin
        next_word.ferr = ~stop_ok_i;
        next_word.data = bits_i[7:0];
        next_word.hi   = 1'b0;
        case (mode_i)
            FMT_8N: next_word.hi = 1'b0;
            FMT_7P: begin
                next_word.data = {1'b0, bits_i[6:0]};
                next_word.hi   = (^bits_i[7:0]) ^ odd_i;
            end
            FMT_8P: next_word.hi = (^bits_i[8:0]) ^ odd_i;
            FMT_9D, FMT_8W: next_word.hi = bits_i[8];
            default: next_word.hi = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            word_q  <= '0;
            mode_q  <= FMT_8N;
        end else begin
            valid_q <= done_i;
            if (done_i) begin
                word_q <= next_word;
                mode_q <= mode_i;
            end
        end
    end

    assign valid_o = valid_q;
    assign word_o  = word_q;
    assign mode_o  = mode_q;
endmodule

// File: rtl/uart_rx_framer.sv
module uart_rx_framer
    import uart_rxf_pkg::*;
#(
    parameter int OVS         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick16_i,
    input  logic [2:0]        fmt_i,
    input  logic [1:0]        stop_i,
    input  logic              par_odd_i,
    input  logic              loop_en_i,
    input  logic              rx_en_i,
    input  logic              rx_i,
    input  logic              tx_i,
    output logic              word_valid_o,
    output logic [WORD_W-1:0] word_o
);
    logic               line;
    frame_cfg_t         cfg_now;
    logic               samp_done;
    logic [SHIFT_W-1:0] samp_bits;
    logic               samp_stop_ok;
    logic [2:0]         samp_mode;
    logic               samp_odd;
    rx_state_e          samp_state;
    logic [2:0]         out_mode;

    assign cfg_now = '{mode: fmt_i, stop: stop_len_e'(stop_i), odd: par_odd_i};

    uart_rxf_linesel #(.SYNC_STAGES(SYNC_STAGES)) u_line (
        .clk       (clk),
        .rst       (rst),
        .loop_en_i (loop_en_i),
        .rx_i      (rx_i),
        .tx_i      (tx_i),
        .line_o    (line)
    );

    uart_rxf_sampler #(.OVS(OVS)) u_samp (
        .clk       (clk),
        .rst       (rst),
        .tick_i    (tick16_i),
        .line_i    (line),
        .en_i      (rx_en_i),
        .cfg_i     (cfg_now),
        .done_o    (samp_done),
        .bits_o    (samp_bits),
        .stop_ok_o (samp_stop_ok),
        .mode_o    (samp_mode),
        .odd_o     (samp_odd),
        .state_o   (samp_state)
    );

    uart_rxf_pack u_pack (
        .clk       (clk),
        .rst       (rst),
        .done_i    (samp_done),
        .bits_i    (samp_bits),
        .stop_ok_i (samp_stop_ok),
        .mode_i    (samp_mode),
        .odd_i     (samp_odd),
        .valid_o   (word_valid_o),
        .word_o    (word_o),
        .mode_o    (out_mode)
    );
endmodule

// File: rtl/uart_rx_framer_chk.sv
module uart_rx_framer_chk
    import uart_rxf_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              tick16_i,
    input logic              rx_en_i,
    input logic              word_valid_o,
    input logic [WORD_W-1:0] word_o,
    input logic [2:0]        out_mode,
    input rx_state_e         samp_state
);
    assert_single_pulse_R12: assert property (@(posedge clk) disable iff (rst)
        word_valid_o |=> !word_valid_o);

    assert_tick_paced_R12: assert property (@(posedge clk) disable iff (rst)
        word_valid_o |-> $past(tick16_i, 2));

    assert_plain_no_b8_R1: assert property (@(posedge clk) disable iff (rst)
        (word_valid_o && out_mode == FMT_8N) |-> (word_o[8] == 1'b0));

    assert_seven_bit_R3: assert property (@(posedge clk) disable iff (rst)
        (word_valid_o && out_mode == FMT_7P) |-> (word_o[7] == 1'b0));

    assert_fmt_supported_R10: assert property (@(posedge clk) disable iff (rst)
        word_valid_o |-> fmt_ok(out_mode));

    assert_idle_when_off_R8: assert property (@(posedge clk) disable iff (rst)
        (samp_state == ST_IDLE && !rx_en_i) |=> (samp_state == ST_IDLE));
endmodule

bind uart_rx_framer uart_rx_framer_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .tick16_i     (tick16_i),
    .rx_en_i      (rx_en_i),
    .word_valid_o (word_valid_o),
    .word_o       (word_o),
    .out_mode     (out_mode),
    .samp_state   (samp_state)
);

// File: tb/test_uart_rx_framer.sv
`timescale 1ns/1ps
module test_uart_rx_framer;
    localparam int NVEC = 12;
    // {mode[26:24], odd[23], serial bits[22:14], nbits[13:10], expected[9:0]}
    localparam logic [26:0] VEC [NVEC] = '{
        {3'd1, 1'b0, 9'h0A5, 4'd8, 10'h0A5},
        {3'd1, 1'b0, 9'h03C, 4'd8, 10'h03C},
        {3'd7, 1'b0, 9'h05A, 4'd9, 10'h05A},
        {3'd7, 1'b0, 9'h15A, 4'd9, 10'h15A},
        {3'd7, 1'b1, 9'h007, 4'd9, 10'h007},
        {3'd7, 1'b1, 9'h107, 4'd9, 10'h107},
        {3'd3, 1'b0, 9'h055, 4'd8, 10'h055},
        {3'd3, 1'b0, 9'h0C1, 4'd8, 10'h141},
        {3'd3, 1'b1, 9'h07F, 4'd8, 10'h07F},
        {3'd4, 1'b0, 9'h1A3, 4'd9, 10'h1A3},
        {3'd5, 1'b0, 9'h0FF, 4'd9, 10'h0FF},
        {3'd4, 1'b1, 9'h100, 4'd9, 10'h100}
    };

    logic clk = 1'b0, rst = 1'b1, tick = 1'b0;
    logic [2:0] fmt = 3'd1;
    logic [1:0] stp = 2'd1;
    logic odd = 1'b0, loop = 1'b0, en = 1'b1;
    logic rx = 1'b1, tx = 1'b1;
    logic use_tx = 1'b0;
    logic word_valid;
    logic [9:0] word;

    int n_checks = 0, n_err = 0;
    logic [9:0] cap [16];
    int cap_n = 0;
    int dbl = 0;
    logic prev_v = 1'b0;

    uart_rx_framer i_uart_rx_framer (
        .clk(clk), .rst(rst), .tick16_i(tick), .fmt_i(fmt), .stop_i(stp),
        .par_odd_i(odd), .loop_en_i(loop), .rx_en_i(en), .rx_i(rx), .tx_i(tx),
        .word_valid_o(word_valid), .word_o(word)
    );

    always #4 clk = ~clk;

    initial forever begin
        @(negedge clk);
        tick = rst ? 1'b0 : ~tick;
    end

    always @(negedge clk) begin
        if (!rst && word_valid) begin
            if (cap_n < 16) cap[cap_n] = word;
            cap_n++;
            if (prev_v) dbl++;
        end
        prev_v = word_valid && !rst;
    end

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_err++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        summary();
        $finish;
    end

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic wait_ticks(input int n);
        repeat (n * 2) @(negedge clk);
    endtask

    task automatic drive(input logic v);
        if (use_tx) tx = v; else rx = v;
    endtask

    task automatic send_bits(input logic [8:0] b, input int n, input int stop_ticks);
        drive(1'b0); wait_ticks(16);
        for (int i = 0; i < n; i++) begin
            drive(b[i]); wait_ticks(16);
        end
        drive(1'b1); wait_ticks(stop_ticks);
    endtask

    task automatic expect_words(input string tag, input int n, input logic [9:0] w0,
                                input logic [9:0] w1, input logic [9:0] w2);
        check(cap_n == n, tag, "word count", cap_n, n);
        if (n > 0 && cap_n > 0) check(cap[0] == w0, tag, "word0", int'(cap[0]), int'(w0));
        if (n > 1 && cap_n > 1) check(cap[1] == w1, tag, "word1", int'(cap[1]), int'(w1));
        if (n > 2 && cap_n > 2) check(cap[2] == w2, tag, "word2", int'(cap[2]), int'(w2));
        cap_n = 0;
    endtask

    initial begin
        string tag;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(word_valid == 1'b0, "R12", "valid after reset", int'(word_valid), 0);
        wait_ticks(20);

        // Vector table: R1, R2, R3, R4
        for (int i = 0; i < NVEC; i++) begin
            fmt = VEC[i][26:24];
            odd = VEC[i][23];
            stp = 2'd1;
            case (fmt)
                3'd1: tag = "R1";
                3'd7: tag = "R2";
                3'd3: tag = "R3";
                default: tag = "R4";
            endcase
            cap_n = 0;
            send_bits(VEC[i][22:14], int'(VEC[i][13:10]), 16);
            wait_ticks(8);
            expect_words(tag, 1, VEC[i][9:0], 10'h0, 10'h0);
        end
        fmt = 3'd1; odd = 1'b0;

        // R5: break gives one word
        cap_n = 0;
        drive(1'b0); wait_ticks(16 * 12);
        drive(1'b1); wait_ticks(24);
        expect_words("R5", 1, 10'h200, 10'h0, 10'h0);

        // R5: framing error with data
        drive(1'b0); wait_ticks(16);
        for (int i = 0; i < 8; i++) begin
            drive(i == 0 || i == 7); wait_ticks(16);
        end
        drive(1'b0); wait_ticks(16);
        drive(1'b1); wait_ticks(24);
        expect_words("R5", 1, 10'h281, 10'h0, 10'h0);

        // R6: short glitch rejected
        drive(1'b0); wait_ticks(4);
        drive(1'b1); wait_ticks(40);
        expect_words("R6", 0, 10'h0, 10'h0, 10'h0);

        // R7: half-bit stops back to back
        stp = 2'd0;
        send_bits(9'h011, 8, 8);
        send_bits(9'h022, 8, 8);
        send_bits(9'h033, 8, 16);
        expect_words("R7", 3, 10'h011, 10'h022, 10'h033);

        // R7: one-bit stop sampled mid stop; stop high only 7 ticks
        stp = 2'd1;
        send_bits(9'h05A, 8, 7);
        drive(1'b0); wait_ticks(24);
        drive(1'b1); wait_ticks(24);
        expect_words("R7", 1, 10'h25A, 10'h0, 10'h0);

        // R7: two stop bits
        stp = 2'd3;
        send_bits(9'h0C3, 8, 32);
        expect_words("R7", 1, 10'h0C3, 10'h0, 10'h0);
        stp = 2'd1;

        // R8: receive disabled, then enabled
        en = 1'b0;
        send_bits(9'h055, 8, 24);
        expect_words("R8", 0, 10'h0, 10'h0, 10'h0);
        en = 1'b1;
        send_bits(9'h055, 8, 24);
        expect_words("R8", 1, 10'h055, 10'h0, 10'h0);

        // R9: loopback uses tx, rx ignored
        loop = 1'b1; wait_ticks(2);
        rx = 1'b0;
        use_tx = 1'b1;
        send_bits(9'h03C, 8, 24);
        expect_words("R9", 1, 10'h03C, 10'h0, 10'h0);
        rx = 1'b1; wait_ticks(4);
        loop = 1'b0; wait_ticks(2);
        tx = 1'b0;
        use_tx = 1'b0;
        send_bits(9'h0C5, 8, 24);
        expect_words("R9", 1, 10'h0C5, 10'h0, 10'h0);
        tx = 1'b1;

        // R10: unsupported format codes
        foreach (VEC[k]) begin end
        for (int m = 0; m < 8; m++) begin
            if (m == 0 || m == 2 || m == 6) begin
                fmt = 3'(m);
                send_bits(9'h055, 8, 24);
                expect_words("R10", 0, 10'h0, 10'h0, 10'h0);
            end
        end
        fmt = 3'd1;

        // R11: format change mid-frame has no effect
        drive(1'b0); wait_ticks(16);
        drive(1'b1); wait_ticks(16 * 3);
        fmt = 3'd4; odd = 1'b1;
        wait_ticks(16 * 5);
        wait_ticks(24);
        fmt = 3'd1; odd = 1'b0;
        expect_words("R11", 1, 10'h0FF, 10'h0, 10'h0);

        // R12: reset mid-frame gives no word
        drive(1'b0); wait_ticks(16);
        drive(1'b0); wait_ticks(16 * 3);
        drive(1'b1);
        rst = 1'b1; repeat (3) @(negedge clk);
        rst = 1'b0;
        wait_ticks(16 * 8);
        expect_words("R12", 0, 10'h0, 10'h0, 10'h0);
        check(dbl == 0, "R12", "multi-cycle valid pulses", dbl, 0);

        summary();
        $finish;
    end
endmodule